// File: doc/BRIEF.md
# PWM Capture-to-Trigger Calculator

This block samples a PWM time-base counter when a capture event occurs and holds the sample in a capture register. When trigger generation is on, it also turns the sample into a compare value for a later trigger: it removes the high-side dead time, halves the result to get the midpoint of the high time, adds a small offset and divides by a postscale factor. The quotient goes into one of four trigger registers, and a status flag reports that a fresh value has landed.

Four capture policies decide when another capture may follow:
- one-shot, re-armed by a read;
- one-shot, re-armed by a read followed by a write that sets bit 0;
- free-running;
- steered, which accepts only in the first cycle of a pair and only while the steering input is low.

A sequential divider does the division, one quotient bit per clock. While it runs, further capture events are dropped.

Top module: `pwm_capture_trigger`

## Requirements
- R1: After reset `cap_reg`, all four trigger registers and `trig_done` are 0. An accepted capture loads `cap_reg` with `tb_count` on that clock edge.
- R2: The stored trigger value is floor((floor(D/2) + `trig_ofs`) / P), where D = `cap_reg` − `deadtime_hi`. All values are unsigned and the result is 16 bits.
- R3: A `trig_ps` value of 0 divides by 1. Values 1 to 31 divide by themselves.
- R4: `trig_sel` is sampled at the capture. 0 selects `trig_c`, 1 selects `trig_d`, 2 selects `trig_e` and 3 selects `trig_f`. Only the selected register changes.
- R5: With `trig_en` = 0 at the capture, only `cap_reg` changes. No trigger register is written and `trig_done` is unchanged.
- R6: `trig_done` rises when a trigger value is stored. It falls one clock after a `cap_rd` or `sel_wr` strobe. A store in the same cycle wins.
- R7: `cap_mode` = 0 (one-shot, read re-arm): after an accepted capture, events are ignored until a `cap_rd` strobe.
- R8: `cap_mode` = 1 (one-shot, read+write re-arm): after an accepted capture, events are ignored until a `cap_rd` strobe followed by a `cap_wr` strobe with `cap_wbit0` = 1. A read alone does not re-arm. A write alone does not re-arm. A write with `cap_wbit0` = 0 does not re-arm.
- R9: `cap_mode` = 2 (free-running): every event is accepted while the divider is idle, with no read needed.
- R10: `cap_mode` = 3 (steered): an event is accepted only while `cycle_first` = 1 and `steer` = 0.
- R11: A capture event that arrives while the divider is busy is ignored. `cap_reg` and the pending result keep their values.
- R12: If `deadtime_hi` exceeds the captured count, D saturates to 0 and does not wrap.
- R13: The trigger register and `trig_done` update on the 17th clock edge after the capture edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tb_count | input | 16 | Time-base counter value |
| cap_event | input | 1 | Capture request |
| cycle_first | input | 1 | High in the first cycle of a steered pair |
| steer | input | 1 | Steering state; captures in mode 3 need it low |
| deadtime_hi | input | 16 | High-side dead-time count |
| trig_en | input | 1 | Enables trigger computation |
| trig_sel | input | 2 | Trigger register select |
| sel_wr | input | 1 | Strobe: select field written |
| trig_ofs | input | 5 | Offset added to the half value |
| trig_ps | input | 5 | Postscale divisor (0 means 1) |
| cap_mode | input | 2 | Capture re-arm policy |
| cap_rd | input | 1 | Strobe: capture register read |
| cap_wr | input | 1 | Strobe: capture register written |
| cap_wbit0 | input | 1 | Bit 0 of the capture register write data |
| cap_reg | output | 16 | Captured count |
| trig_c | output | 16 | Trigger register 0 |
| trig_d | output | 16 | Trigger register 1 |
| trig_e | output | 16 | Trigger register 2 |
| trig_f | output | 16 | Trigger register 3 |
| trig_done | output | 1 | New trigger value stored |

## Verification
The bench targets these corner cases:

| Corner case | What a faulty design would do |
|---|---|
| Dead time larger than the count | Wrap to a huge difference and store a value near 32768 instead of offset/postscale |
| Postscale of zero | Hang the divider or return all ones instead of treating the field as 1 |
| Capture events arriving while the divider runs | Load `cap_reg` again or restart the division, so the stored trigger would match the second sample |
| Partial re-arm sequences in mode 1 | Re-arm on the wrong half of the read+write sequence and let an extra capture through |
| Steered capture | Capture on `cycle_first` = 0 or with `steer` high |
| Exact store cycle | Show the flag one clock early or late |

// File: rtl/ctt_pkg.sv
package ctt_pkg;
  parameter int unsigned CTT_W  = 16;
  parameter int unsigned CTT_FW = 5;

  typedef enum logic [1:0] {
    CM_READ_ARM   = 2'd0,
    CM_RDWR_ARM   = 2'd1,
    CM_FREE_RUN   = 2'd2,
    CM_STEERED    = 2'd3
  } cap_mode_e;

  // half of the high time after dead-time removal, plus offset
  function automatic logic [CTT_W-1:0] ctt_numerator(
    input logic [CTT_W-1:0]  cnt,
    input logic [CTT_W-1:0]  dt,
    input logic [CTT_FW-1:0] ofs
  );
    logic [CTT_W-1:0] diff;
    logic [CTT_W:0]   sum;
    diff = (cnt > dt) ? (cnt - dt) : '0;
    sum  = {1'b0, diff >> 1} + {{(CTT_W+1-CTT_FW){1'b0}}, ofs};
    return sum[CTT_W-1:0];
  endfunction

  function automatic logic [CTT_FW-1:0] ctt_divisor(input logic [CTT_FW-1:0] ps);
    return (ps == '0) ? CTT_FW'(1) : ps;
  endfunction
endpackage

// File: rtl/ctt_divider.sv
module ctt_divider #(
  parameter int unsigned W  = 16,
  parameter int unsigned DW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  num,
  input  logic [DW-1:0] den,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  quo
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  rem;
  logic [DW-1:0] den_q;
  logic [CW-1:0] left;
  logic [W:0]    shifted;
  logic [W:0]    trial;

  always_comb begin
    shifted = {rem, quo[W-1]};
    trial   = shifted - {{(W+1-DW){1'b0}}, den_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem   <= '0;
      quo   <= '0;
      den_q <= '0;
      left  <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        rem   <= '0;
        quo   <= num;
        den_q <= den;
        left  <= CW'(W);
        busy  <= 1'b1;
      end else if (busy) begin
        if (!trial[W]) begin
          rem <= trial[W-1:0];
          quo <= {quo[W-2:0], 1'b1};
        end else begin
          rem <= shifted[W-1:0];
          quo <= {quo[W-2:0], 1'b0};
        end
        left <= left - CW'(1);
        if (left == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ctt_arm.sv
module ctt_arm
  import ctt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cap_mode_e mode,
  input  logic      cap_event,
  input  logic      cycle_first,
  input  logic      steer,
  input  logic      cap_rd,
  input  logic      cap_wr,
  input  logic      cap_wbit0,
  input  logic      blocked,
  output logic      accept,
  output logic      armed
);
  logic rd_seen;
  logic gate;

  always_comb begin
    unique case (mode)
      CM_READ_ARM, CM_RDWR_ARM: gate = armed;
      CM_FREE_RUN:              gate = 1'b1;
      default:                  gate = cycle_first && !steer;
    endcase
    accept = cap_event && !blocked && gate;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b1;
      rd_seen <= 1'b0;
    end else if (accept && (mode == CM_READ_ARM || mode == CM_RDWR_ARM)) begin
      armed   <= 1'b0;
      rd_seen <= 1'b0;
    end else if (mode == CM_READ_ARM) begin
      if (cap_rd) armed <= 1'b1;
    end else if (mode == CM_RDWR_ARM) begin
      if (cap_wr && cap_wbit0 && rd_seen) begin
        armed   <= 1'b1;
        rd_seen <= 1'b0;
      end else if (cap_rd) begin
        rd_seen <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ctt_trig_bank.sv
module ctt_trig_bank #(
  parameter int unsigned W  = 16,
  parameter int unsigned N  = 4,
  parameter int unsigned SW = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                store,
  input  logic [SW-1:0]       sel,
  input  logic [W-1:0]        value,
  output logic [N-1:0]        we,
  output logic [N-1:0][W-1:0] regs
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    assign we[g] = store && (sel == SW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     regs[g] <= '0;
      else if (we[g]) regs[g] <= value;
    end
  end
endmodule

// File: rtl/pwm_capture_trigger.sv
module pwm_capture_trigger
  import ctt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] tb_count,
  input  logic        cap_event,
  input  logic        cycle_first,
  input  logic        steer,
  input  logic [15:0] deadtime_hi,
  input  logic        trig_en,
  input  logic [1:0]  trig_sel,
  input  logic        sel_wr,
  input  logic [4:0]  trig_ofs,
  input  logic [4:0]  trig_ps,
  input  logic [1:0]  cap_mode,
  input  logic        cap_rd,
  input  logic        cap_wr,
  input  logic        cap_wbit0,
  output logic [15:0] cap_reg,
  output logic [15:0] trig_c,
  output logic [15:0] trig_d,
  output logic [15:0] trig_e,
  output logic [15:0] trig_f,
  output logic        trig_done
);
  localparam int unsigned NTRIG = 4;
  localparam int unsigned SW    = $clog2(NTRIG);

  logic                    accept;
  logic                    armed;
  logic                    start;
  logic                    div_busy;
  logic                    store;
  logic [CTT_W-1:0]        quotient;
  logic [SW-1:0]           sel_q;
  logic [NTRIG-1:0]        bank_we;
  logic [NTRIG-1:0][CTT_W-1:0] bank;

  ctt_arm u_arm (
    .clk(clk), .rst_n(rst_n), .mode(cap_mode_e'(cap_mode)),
    .cap_event(cap_event), .cycle_first(cycle_first), .steer(steer),
    .cap_rd(cap_rd), .cap_wr(cap_wr), .cap_wbit0(cap_wbit0),
    .blocked(div_busy), .accept(accept), .armed(armed)
  );

  assign start = accept && trig_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_reg <= '0;
      sel_q   <= '0;
    end else if (accept) begin
      cap_reg <= tb_count;
      if (trig_en) sel_q <= trig_sel;
    end
  end

  ctt_divider #(.W(CTT_W), .DW(CTT_FW)) u_div (
    .clk(clk), .rst_n(rst_n), .start(start),
    .num(ctt_numerator(tb_count, deadtime_hi, trig_ofs)),
    .den(ctt_divisor(trig_ps)),
    .busy(div_busy), .done(store), .quo(quotient)
  );

  ctt_trig_bank #(.W(CTT_W), .N(NTRIG), .SW(SW)) u_bank (
    .clk(clk), .rst_n(rst_n), .store(store), .sel(sel_q),
    .value(quotient), .we(bank_we), .regs(bank)
  );

  assign trig_c = bank[0];
  assign trig_d = bank[1];
  assign trig_e = bank[2];
  assign trig_f = bank[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                trig_done <= 1'b0;
    else if (store)            trig_done <= 1'b1;
    else if (cap_rd || sel_wr) trig_done <= 1'b0;
  end
endmodule

// File: rtl/ctt_checker.sv
module ctt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] tb_count,
  input logic        cap_event,
  input logic        cycle_first,
  input logic        steer,
  input logic [1:0]  cap_mode,
  input logic        trig_en,
  input logic        cap_rd,
  input logic        sel_wr,
  input logic [15:0] cap_reg,
  input logic        trig_done,
  input logic        accept,
  input logic        div_busy,
  input logic        store,
  input logic [3:0]  bank_we
);
  assert_capture_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> cap_reg == $past(tb_count));

  assert_busy_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_event && div_busy) |=> $stable(cap_reg));

  assert_single_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    store |-> $countones(bank_we) == 1);

  assert_no_write_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !store |-> bank_we == 4'b0000);

  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    store |=> trig_done);

  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!store && (cap_rd || sel_wr)) |=> !trig_done);

  assert_no_divide_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !trig_en) |=> !div_busy);

  assert_steer_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_mode == 2'd3 && (steer || !cycle_first)) |=> $stable(cap_reg));
endmodule

bind pwm_capture_trigger ctt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tb_count(tb_count), .cap_event(cap_event),
  .cycle_first(cycle_first), .steer(steer), .cap_mode(cap_mode),
  .trig_en(trig_en), .cap_rd(cap_rd), .sel_wr(sel_wr), .cap_reg(cap_reg),
  .trig_done(trig_done), .accept(accept), .div_busy(div_busy),
  .store(store), .bank_we(bank_we)
);

// File: tb/sim_pwm_capture_trigger.sv
`timescale 1ns/1ps
module sim_pwm_capture_trigger;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] tb_count = '0;
  logic cap_event = 0, cycle_first = 0, steer = 0;
  logic [15:0] deadtime_hi = '0;
  logic trig_en = 0;
  logic [1:0] trig_sel = '0;
  logic sel_wr = 0;
  logic [4:0] trig_ofs = '0, trig_ps = '0;
  logic [1:0] cap_mode = 2'd2;
  logic cap_rd = 0, cap_wr = 0, cap_wbit0 = 0;
  logic [15:0] cap_reg, trig_c, trig_d, trig_e, trig_f;
  logic trig_done;

  int n_tests = 0;
  int n_fail = 0;
  int exp_trig [4];

  always #10 clk = ~clk;

  pwm_capture_trigger u0 (.*);

  function automatic int model(int cnt, int dt, int ofs, int ps);
    int d;
    d = (cnt > dt) ? cnt - dt : 0;
    return ((d / 2) + ofs) / ((ps == 0) ? 1 : ps);
  endfunction

  function automatic int trig_out(int idx);
    case (idx)
      0: return int'(trig_c);
      1: return int'(trig_d);
      2: return int'(trig_e);
      default: return int'(trig_f);
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic capture(int cnt);
    tb_count = 16'(cnt); cap_event = 1; tick(); cap_event = 0;
  endtask

  task automatic rd();  cap_rd = 1; tick(); cap_rd = 0; endtask
  task automatic selw(); sel_wr = 1; tick(); sel_wr = 0; endtask
  task automatic wr(bit b); cap_wr = 1; cap_wbit0 = b; tick(); cap_wr = 0; cap_wbit0 = 0; endtask

  task automatic check_bank(string req);
    for (int i = 0; i < 4; i++) check(req, trig_out(i), exp_trig[i]);
  endtask

  task automatic setup(int dt, int ofs, int ps, int sel, bit en);
    deadtime_hi = 16'(dt); trig_ofs = 5'(ofs); trig_ps = 5'(ps);
    trig_sel = 2'(sel); trig_en = en;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < 4; i++) exp_trig[i] = 0;
    tick(2);
    // R1 reset state
    check("R1 reset cap", int'(cap_reg), 0);
    check("R1 reset flag", int'(trig_done), 0);
    check_bank("R1 reset trig");
    rst_n = 1; tick();

    // R13/R2/R3: latency and postscale 0 -> divide by 1
    setup(100, 0, 0, 1, 1);
    capture(1000);
    check("R1 capture", int'(cap_reg), 1000);
    tick(16);
    check("R13 not yet", int'(trig_done), 0);
    tick();
    check("R13 flag at 17", int'(trig_done), 1);
    exp_trig[1] = model(1000, 100, 0, 0);
    check("R3 ps0", int'(trig_d), 450);
    check_bank("R4 only D");

    // R6: select write clears
    selw();
    check("R6 sel_wr clear", int'(trig_done), 0);

    // R12 saturation, R4 select E
    setup(200, 7, 2, 2, 1);
    capture(50);
    tick(18);
    exp_trig[2] = 3;
    check("R12 saturate", int'(trig_e), model(50, 200, 7, 2));
    check_bank("R4 only E");
    check("R6 flag set", int'(trig_done), 1);
    rd();
    check("R6 read clear", int'(trig_done), 0);

    // R5 disabled
    setup(0, 3, 1, 0, 0);
    capture(1234);
    check("R5 cap", int'(cap_reg), 1234);
    tick(20);
    check_bank("R5 no trig");
    check("R5 flag", int'(trig_done), 0);

    // R11 busy ignore
    setup(0, 1, 5, 3, 1);
    capture(3000);
    tick(3);
    capture(9999);
    check("R11 cap held", int'(cap_reg), 3000);
    tick(18);
    exp_trig[3] = 300;
    check("R11 result", int'(trig_f), model(3000, 0, 1, 5));
    check_bank("R11 bank");
    selw();

    // R9 free-running back to back
    setup(0, 0, 1, 0, 0);
    capture(11);
    capture(22);
    check("R9 second", int'(cap_reg), 22);

    // R7 read re-arm
    cap_mode = 2'd0;
    capture(500);
    check("R7 first", int'(cap_reg), 500);
    capture(600);
    check("R7 ignored", int'(cap_reg), 500);
    rd();
    capture(700);
    check("R7 rearmed", int'(cap_reg), 700);

    // R8 read+write re-arm
    cap_mode = 2'd1;
    rd(); wr(1);
    capture(800);
    check("R8 first", int'(cap_reg), 800);
    wr(1);
    capture(801);
    check("R8 write alone", int'(cap_reg), 800);
    rd();
    capture(802);
    check("R8 read alone", int'(cap_reg), 800);
    wr(0);
    capture(803);
    check("R8 bit0 low", int'(cap_reg), 800);
    wr(1);
    capture(804);
    check("R8 rearmed", int'(cap_reg), 804);

    // R10 steered
    cap_mode = 2'd3;
    cycle_first = 1; steer = 1;
    capture(900);
    check("R10 steer high", int'(cap_reg), 804);
    cycle_first = 0; steer = 0;
    capture(901);
    check("R10 second cycle", int'(cap_reg), 804);
    cycle_first = 1;
    capture(902);
    check("R10 accepted", int'(cap_reg), 902);
    cycle_first = 0;

    // R2 random, free-running
    cap_mode = 2'd2;
    for (int it = 0; it < 150; it++) begin
      int cnt, dt, ofs, ps, sel;
      bit en;
      cnt = int'($urandom_range(0, 65535));
      dt  = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 65535))
                                         : int'($urandom_range(0, 400));
      ofs = int'($urandom_range(0, 31));
      ps  = int'($urandom_range(0, 31));
      sel = int'($urandom_range(0, 3));
      en  = ($urandom_range(0, 4) != 0);
      setup(dt, ofs, ps, sel, en);
      capture(cnt);
      tick(18);
      if (en) exp_trig[sel] = model(cnt, dt, ofs, ps);
      check("R2 cap", int'(cap_reg), cnt);
      check("R2 flag", int'(trig_done), int'(en));
      check_bank("R2 trig");
      selw();
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule